// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block sits beside a processor core and counts what the core reports. It holds a bank of programmable event counters and one free-running cycle counter. Each event counter is bound by software to one of the core's single-cycle event pulses, or to a software-driven increment. A word-addressed register port sets up, starts, stops, preloads and reads the counters. A level interrupt is raised while any counter that is allowed to interrupt shows a pending overflow.

The event counters are reached indirectly: a select register names one counter, and the event-type and counter-value registers act on that counter alone. Enables, interrupt enables and overflow flags are kept as masks. Enables and interrupt enables change through separate set and clear registers. Overflow flags clear when a one is written to them. In each mask, bits 0 to 5 belong to the event counters and bit 31 belongs to the cycle counter. The cycle counter can be slowed so that it advances once every 64 clocks.

Register addresses on `reg_addr`: 0 control, 1 enable-set, 2 enable-clear, 3 overflow flags, 4 software increment, 5 counter select, 6 cycle counter value, 7 event type, 8 event counter value, 9 interrupt-enable set, 10 interrupt-enable clear, 11 user access.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every counter, mask, select and user-access register reads zero and `irq` is low. The control register (address 0) reads the number of event counters, 6, in bits 15:11, so it reads 0x3000.
- R2: An event counter whose type is k (1 to 16) adds one at each clock edge where `evt_in[k-1]` is high, its enable bit is set and the global enable (control bit 0) is set. Pulses on other lines leave it unchanged.
- R3: Writing ones to address 1 sets the matching enable bits, and writing ones to address 2 clears them. Zero bits leave enables unchanged. Reading either address returns the mask, with bit 31 for the cycle counter and bits 0 to 5 for the event counters.
- R4: Address 5 selects a counter. Addresses 7 (event type) and 8 (value) read and write only the selected counter. A select of 6 or above reads zero.
- R5: While control bit 0 is clear, no counter changes, not even from a software increment.
- R6: Writing a one to bit i of address 4 adds one to counter i only if its event type is 0, the software-increment code.
- R7: A counter that increments from all ones wraps to zero and sets its own bit in the overflow flags (address 3). Writing a one to a flag clears it.
- R8: `irq` is high exactly while some counter has both its overflow flag and its interrupt enable set. Interrupt enables are set through address 9 and cleared through address 10.
- R9: With the divider off, the enabled cycle counter (address 6) adds one at every clock edge.
- R10: With control bit 3 set, the cycle counter adds one only on every 64th clock edge that counting is enabled.
- R11: Writing a one to control bit 1 zeroes all event counters, and writing a one to control bit 2 zeroes the cycle counter. Both bits clear themselves and read back zero, and a reset wins over an increment in the same cycle.
- R12: While `reg_priv` is low and the user-access bit (address 11, bit 0) is clear, reads return zero and writes are ignored. The user-access bit itself is written only by privileged accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Word address of the register accessed |
| reg_wr | input | 1 | Write strobe, taken at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_priv | input | 1 | High for a privileged access |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | 16 | Single-cycle event pulses from the core |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench uses the default parameters: six 32-bit event counters, sixteen event lines and a 64-clock divider. Full 32-bit counters are kept. Wrap-around is reached by preloading 0xFFFFFFFF through the value registers rather than by shrinking the width. With the 64-clock divider, two divided ticks fit within 130 cycles, so the divider is checked at its real ratio.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int DATA_W = 32;
  localparam int SEL_W  = 5;

  typedef enum logic [3:0] {
    RA_CTRL     = 4'd0,
    RA_EN_SET   = 4'd1,
    RA_EN_CLR   = 4'd2,
    RA_OVF      = 4'd3,
    RA_SWINC    = 4'd4,
    RA_SEL      = 4'd5,
    RA_CYC_VAL  = 4'd6,
    RA_EVT_TYPE = 4'd7,
    RA_EVT_VAL  = 4'd8,
    RA_IRQ_SET  = 4'd9,
    RA_IRQ_CLR  = 4'd10,
    RA_USER     = 4'd11
  } pmu_reg_e;

  localparam int CTRL_EN_BIT      = 0;
  localparam int CTRL_RST_EVT_BIT = 1;
  localparam int CTRL_RST_CYC_BIT = 2;
  localparam int CTRL_DIV_BIT     = 3;
  localparam int CTRL_N_LSB       = 11;
  localparam int CTRL_N_W         = 5;
  localparam int CYC_BIT          = 31;

  // Mask of mask bits that exist: event counters low, cycle counter at the top.
  function automatic logic [DATA_W-1:0] impl_mask(input int n_evt);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < DATA_W; k++) begin
      if (k < n_evt) m[k] = 1'b1;
    end
    m[CYC_BIT] = 1'b1;
    return m;
  endfunction

  // Control register read image.
  function automatic logic [DATA_W-1:0] ctrl_image(input int n_evt, input logic en, input logic div);
    logic [DATA_W-1:0] v;
    v = '0;
    v[CTRL_N_LSB +: CTRL_N_W] = CTRL_N_W'(n_evt);
    v[CTRL_EN_BIT]  = en;
    v[CTRL_DIV_BIT] = div;
    return v;
  endfunction

endpackage

// File: rtl/pmu_evt_ctr.sv
module pmu_evt_ctr #(
  parameter int CNT_W   = 32,
  parameter int NUM_SRC = 16,
  parameter int TYPE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic              type_wr,
  input  logic [TYPE_W-1:0] type_wdata,
  input  logic              val_wr,
  input  logic [CNT_W-1:0]  val_wdata,
  input  logic              sw_hit,
  input  logic [NUM_SRC-1:0] src,
  output logic [TYPE_W-1:0] type_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              wrap
);

  // Adds one when asked; the top bit of the result is the carry out.
  function automatic logic [CNT_W:0] bump(input logic [CNT_W-1:0] v, input logic inc);
    return {1'b0, v} + (CNT_W+1)'(inc);
  endfunction

  logic             hit;
  logic             inc;
  logic [CNT_W:0]   sum;

  // Event code 0 means software increment, code k means source line k-1.
  always_comb begin
    hit = (type_q == '0) ? sw_hit : 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (type_q == TYPE_W'(k + 1)) hit = src[k];
    end
  end

  assign inc  = run & hit;
  assign sum  = bump(cnt_q, inc);
  assign wrap = sum[CNT_W] & ~clr & ~val_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
    end else if (type_wr) begin
      type_q <= type_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (val_wr) begin
      cnt_q <= val_wdata;
    end else begin
      cnt_q <= sum[CNT_W-1:0];
    end
  end

  // R11
  evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R5
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr && !val_wr) |=> $stable(cnt_q));

  // R7
  evt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));

endmodule

// File: rtl/pmu_cyc_ctr.sv
module pmu_cyc_ctr #(
  parameter int CNT_W    = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             div,
  input  logic             clr,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] val_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tick,
  output logic             wrap
);

  logic [DIV_LOG2-1:0] pre_q;
  logic [CNT_W:0]      sum;

  assign tick = run & (~div | (pre_q == '1));
  assign sum  = {1'b0, cnt_q} + (CNT_W+1)'(tick);
  assign wrap = sum[CNT_W] & ~clr & ~val_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clr) begin
      pre_q <= '0;
    end else if (run && div) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (val_wr) begin
      cnt_q <= val_wdata;
    end else begin
      cnt_q <= sum[CNT_W-1:0];
    end
  end

  // R9
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !div && !clr && !val_wr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R10
  cyc_div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div && !clr) |=> !tick);

  // R11
  cyc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit #(
  parameter int NUM_EVT  = 6,
  parameter int CNT_W    = 32,
  parameter int NUM_SRC  = 16,
  parameter int TYPE_W   = 8,
  parameter int DIV_LOG2 = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  input  logic                 reg_priv,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_SRC-1:0]   evt_in,
  output logic                 irq
);
  import pmu_pkg::*;

  localparam logic [DATA_W-1:0] IMPL = impl_mask(NUM_EVT);

  // Control and mask state
  logic                     ctrl_en_q;
  logic                     ctrl_div_q;
  logic [DATA_W-1:0]        en_q;
  logic [DATA_W-1:0]        ovf_q;
  logic [DATA_W-1:0]        inten_q;
  logic [SEL_W-1:0]         sel_q;
  logic                     user_q;

  // Access qualification and write decode
  logic acc_ok, wr_ok;
  logic wr_ctrl, wr_enset, wr_enclr, wr_ovf, wr_swinc, wr_sel;
  logic wr_cyc, wr_type, wr_val, wr_iset, wr_iclr, wr_user;
  logic clr_evt, clr_cyc;
  logic sel_valid;

  assign acc_ok   = reg_priv | user_q;
  assign wr_ok    = reg_wr & acc_ok;
  assign wr_ctrl  = wr_ok && (reg_addr == RA_CTRL);
  assign wr_enset = wr_ok && (reg_addr == RA_EN_SET);
  assign wr_enclr = wr_ok && (reg_addr == RA_EN_CLR);
  assign wr_ovf   = wr_ok && (reg_addr == RA_OVF);
  assign wr_swinc = wr_ok && (reg_addr == RA_SWINC);
  assign wr_sel   = wr_ok && (reg_addr == RA_SEL);
  assign wr_cyc   = wr_ok && (reg_addr == RA_CYC_VAL);
  assign wr_type  = wr_ok && (reg_addr == RA_EVT_TYPE);
  assign wr_val   = wr_ok && (reg_addr == RA_EVT_VAL);
  assign wr_iset  = wr_ok && (reg_addr == RA_IRQ_SET);
  assign wr_iclr  = wr_ok && (reg_addr == RA_IRQ_CLR);
  assign wr_user  = reg_wr && reg_priv && (reg_addr == RA_USER);

  assign clr_evt   = wr_ctrl & reg_wdata[CTRL_RST_EVT_BIT];
  assign clr_cyc   = wr_ctrl & reg_wdata[CTRL_RST_CYC_BIT];
  assign sel_valid = (32'(sel_q) < NUM_EVT);

  // Counter bank
  logic [CNT_W-1:0]  ev_cnt  [NUM_EVT];
  logic [TYPE_W-1:0] ev_type [NUM_EVT];
  logic [NUM_EVT-1:0] ev_wrap;
  logic [CNT_W-1:0]  cyc_cnt;
  logic              cyc_wrap;
  logic              cyc_tick;
  logic [DATA_W-1:0] wrap_vec;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    logic sel_me;
    assign sel_me = (sel_q == SEL_W'(i));

    pmu_evt_ctr #(
      .CNT_W   (CNT_W),
      .NUM_SRC (NUM_SRC),
      .TYPE_W  (TYPE_W)
    ) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (ctrl_en_q & en_q[i]),
      .clr        (clr_evt),
      .type_wr    (wr_type & sel_me),
      .type_wdata (reg_wdata[TYPE_W-1:0]),
      .val_wr     (wr_val & sel_me),
      .val_wdata  (reg_wdata[CNT_W-1:0]),
      .sw_hit     (wr_swinc & reg_wdata[i]),
      .src        (evt_in),
      .type_q     (ev_type[i]),
      .cnt_q      (ev_cnt[i]),
      .wrap       (ev_wrap[i])
    );
  end

  pmu_cyc_ctr #(
    .CNT_W    (CNT_W),
    .DIV_LOG2 (DIV_LOG2)
  ) u_cyc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl_en_q & en_q[CYC_BIT]),
    .div       (ctrl_div_q),
    .clr       (clr_cyc),
    .val_wr    (wr_cyc),
    .val_wdata (reg_wdata[CNT_W-1:0]),
    .cnt_q     (cyc_cnt),
    .tick      (cyc_tick),
    .wrap      (cyc_wrap)
  );

  always_comb begin
    wrap_vec = '0;
    for (int i = 0; i < NUM_EVT; i++) wrap_vec[i] = ev_wrap[i];
    wrap_vec[CYC_BIT] = cyc_wrap;
  end

  // Register state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q  <= 1'b0;
      ctrl_div_q <= 1'b0;
      en_q       <= '0;
      ovf_q      <= '0;
      inten_q    <= '0;
      sel_q      <= '0;
      user_q     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en_q  <= reg_wdata[CTRL_EN_BIT];
        ctrl_div_q <= reg_wdata[CTRL_DIV_BIT];
      end
      if (wr_enset)      en_q <= en_q | (reg_wdata & IMPL);
      else if (wr_enclr) en_q <= en_q & ~reg_wdata;
      if (wr_iset)       inten_q <= inten_q | (reg_wdata & IMPL);
      else if (wr_iclr)  inten_q <= inten_q & ~reg_wdata;
      ovf_q <= ((ovf_q & ~(wr_ovf ? reg_wdata : '0)) | wrap_vec) & IMPL;
      if (wr_sel)  sel_q  <= reg_wdata[SEL_W-1:0];
      if (wr_user) user_q <= reg_wdata[0];
    end
  end

  assign irq = |(ovf_q & inten_q);

  // Read path
  logic [DATA_W-1:0] rd_raw;
  always_comb begin
    rd_raw = '0;
    case (reg_addr)
      RA_CTRL:     rd_raw = ctrl_image(NUM_EVT, ctrl_en_q, ctrl_div_q);
      RA_EN_SET,
      RA_EN_CLR:   rd_raw = en_q;
      RA_OVF:      rd_raw = ovf_q;
      RA_SEL:      rd_raw = DATA_W'(sel_q);
      RA_CYC_VAL:  rd_raw = DATA_W'(cyc_cnt);
      RA_EVT_TYPE: rd_raw = sel_valid ? DATA_W'(ev_type[sel_q]) : '0;
      RA_EVT_VAL:  rd_raw = sel_valid ? DATA_W'(ev_cnt[sel_q]) : '0;
      RA_IRQ_SET,
      RA_IRQ_CLR:  rd_raw = inten_q;
      RA_USER:     rd_raw = DATA_W'(user_q);
      default:     rd_raw = '0;
    endcase
  end

  assign reg_rdata = acc_ok ? rd_raw : '0;

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_vec) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec)));

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(wrap_vec & inten_q)) && !wr_iclr) |=> irq);

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enclr |=> ((en_q & $past(reg_wdata)) == '0));

  // R12
  user_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_priv && !user_q) |=>
      ($stable(en_q) && $stable(inten_q) && $stable(sel_q) && $stable(ctrl_en_q)));

  // R10
  div_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_tick && ctrl_div_q && !clr_cyc) |=> !cyc_tick);

endmodule

// File: tb/test_perf_mon_unit.sv
module test_perf_mon_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_priv = 1'b1;
  logic [31:0] reg_rdata;
  logic [15:0] evt_in = '0;
  logic        irq;

  perf_mon_unit i_perf_mon_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_priv  (reg_priv),
    .reg_rdata (reg_rdata),
    .evt_in    (evt_in),
    .irq       (irq)
  );

  always #5 clk = ~clk;

  localparam logic [3:0] A_CTRL = 4'd0, A_ENS = 4'd1, A_ENC = 4'd2, A_OVF = 4'd3,
    A_SWI = 4'd4, A_SEL = 4'd5, A_CYC = 4'd6, A_TYP = 4'd7, A_VAL = 4'd8,
    A_IRS = 4'd9, A_IRC = 4'd10, A_USR = 4'd11;
  localparam logic [31:0] N_FIELD = 32'd6 << 11;

  int          vectors = 0;
  int          miscompares = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_active = 1'b0;
  logic        rd_irq = 1'b0;
  logic        done = 1'b0;

  // Monitor: pops one expectation per observed read, away from the edge
  always @(negedge clk) begin
    #2;
    if (rd_active && exp_q.size() > 0) begin
      logic [31:0] obs;
      logic [31:0] e;
      string t;
      obs = rd_irq ? {31'b0, irq} : reg_rdata;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (obs !== e) begin
        miscompares++;
        $display("FAIL %s: got %h expected %h", t, obs, e);
      end
    end
  end

  // Every task starts at a falling edge and returns at the next one.
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    reg_addr = a; rd_irq = 1'b0; rd_active = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_active = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    rd_irq = 1'b1; rd_active = 1'b1;
    exp_q.push_back({31'b0, e}); tag_q.push_back(t);
    @(negedge clk);
    rd_active = 1'b0; rd_irq = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulses(input int line, input int n);
    for (int k = 0; k < n; k++) begin
      evt_in = '0; evt_in[line] = 1'b1;
      @(negedge clk);
    end
    evt_in = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset image
    rd(A_CTRL, N_FIELD, "R1 ctrl");
    rd(A_ENS, 32'h0, "R1 enable mask");
    rd(A_OVF, 32'h0, "R1 overflow");
    rd(A_CYC, 32'h0, "R1 cycle value");
    rd(A_USR, 32'h0, "R1 user bit");
    chk_irq(1'b0, "R1 irq");

    // R2 / R4: program types through the select register
    wr(A_SEL, 0); wr(A_TYP, 1);
    wr(A_SEL, 1); wr(A_TYP, 0);
    wr(A_SEL, 2); wr(A_TYP, 1);
    wr(A_ENS, 32'h3);
    wr(A_CTRL, 32'h1);
    pulses(0, 5);
    pulses(1, 2);
    wr(A_SEL, 0);
    rd(A_VAL, 32'd5, "R2 counter0 five pulses");
    rd(A_TYP, 32'd1, "R4 selected type");
    wr(A_SEL, 2);
    rd(A_VAL, 32'd0, "R2 disabled counter2");
    wr(A_SEL, 1);
    rd(A_TYP, 32'd0, "R4 counter1 type");
    wr(A_SEL, 7);
    rd(A_VAL, 32'd0, "R4 out of range select");

    // R6: software increment obeys type
    wr(A_SWI, 32'h3);
    wr(A_SEL, 1);
    rd(A_VAL, 32'd1, "R6 sw counter");
    wr(A_SEL, 0);
    rd(A_VAL, 32'd5, "R6 event-typed counter");

    // R3: enable clear
    wr(A_ENC, 32'h1);
    pulses(0, 3);
    rd(A_VAL, 32'd5, "R3 cleared counter held");
    rd(A_ENS, 32'h2, "R3 mask after clear");
    rd(A_ENC, 32'h2, "R3 mask via clear addr");

    // R5: global enable gates
    wr(A_CTRL, 32'h0);
    wr(A_SWI, 32'h2);
    wr(A_SEL, 1);
    rd(A_VAL, 32'd1, "R5 global off");

    // R7 / R8: event counter wrap
    wr(A_VAL, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1);
    wr(A_SWI, 32'h2);
    wr(A_CTRL, 32'h0);
    rd(A_VAL, 32'd0, "R7 wrapped value");
    rd(A_OVF, 32'h2, "R7 overflow flag");
    chk_irq(1'b0, "R8 irq masked");
    wr(A_IRS, 32'h2);
    chk_irq(1'b1, "R8 irq raised");
    wr(A_OVF, 32'h2);
    rd(A_OVF, 32'h0, "R7 flag cleared");
    chk_irq(1'b0, "R8 irq dropped");

    // R9: cycle counter, undivided
    wr(A_CYC, 32'h0);
    wr(A_ENS, 32'h8000_0000);
    wr(A_CTRL, 32'h1);
    idle(9);
    wr(A_CTRL, 32'h0);
    rd(A_CYC, 32'd10, "R9 ten clocks");

    // R10: divide by 64
    wr(A_CTRL, 32'h4 | 32'h8);
    wr(A_CTRL, 32'h1 | 32'h8);
    idle(129);
    wr(A_CTRL, 32'h8);
    rd(A_CYC, 32'd2, "R10 divided count");
    rd(A_CTRL, N_FIELD | 32'h8, "R10 divider bit");

    // R11: resets
    wr(A_CTRL, 32'h2);
    wr(A_SEL, 0);
    rd(A_VAL, 32'd0, "R11 event reset");
    rd(A_CYC, 32'd2, "R11 cycle untouched");
    wr(A_CTRL, 32'h4);
    rd(A_CYC, 32'd0, "R11 cycle reset");
    rd(A_CTRL, N_FIELD, "R11 self clearing");
    wr(A_VAL, 32'd3);
    wr(A_ENS, 32'h1);
    wr(A_CTRL, 32'h1);
    evt_in = 16'h0001;
    wr(A_CTRL, 32'h3);
    evt_in = '0;
    wr(A_CTRL, 32'h0);
    rd(A_VAL, 32'd0, "R11 reset beats increment");

    // R7 / R8: cycle counter wrap at bit 31
    wr(A_CYC, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h0);
    rd(A_CYC, 32'd0, "R7 cycle wrapped");
    rd(A_OVF, 32'h8000_0000, "R7 cycle flag");
    wr(A_IRS, 32'h8000_0000);
    chk_irq(1'b1, "R8 cycle irq");
    wr(A_IRC, 32'h8000_0000);
    chk_irq(1'b0, "R8 irq enable cleared");

    // R12: user access
    reg_priv = 1'b0;
    rd(A_ENS, 32'h0, "R12 user read blocked");
    wr(A_ENC, 32'hFFFF_FFFF);
    wr(A_USR, 32'h1);
    reg_priv = 1'b1;
    rd(A_ENS, 32'h8000_0003, "R12 user write ignored");
    rd(A_USR, 32'h0, "R12 user bit unprivileged write");
    wr(A_USR, 32'h1);
    reg_priv = 1'b0;
    rd(A_ENS, 32'h8000_0003, "R12 user read allowed");
    reg_priv = 1'b1;

    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule